// File: doc/BRIEF.md
# Single-Bus Accumulator Processor Core

This block is a small 16-bit accumulator processor. The program counter, memory address register, memory data register, instruction register, accumulator and ALU result register all move data over one shared internal bus. A hardwired controller decides which register drives the bus and which registers load from it in each step. A one-hot ring of eight flip-flops supplies the steps. Each step bit is ANDed with a decoded opcode line to make the transfer strobes.

Every instruction word has a 4-bit opcode in bits 15:12 and a 12-bit word address in bits 11:0. The core fetches, decodes and executes five operations: store, load, add, jump and end. It talks to a word-addressed memory. Reads are combinational, so read data must be valid in the same cycle that the address is presented. Writes are synchronous and take effect on the clock edge at the end of a cycle in which the write enable is high. A halted flag shows when the core has executed an end instruction.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0, `mem_we` is 0 and `halted` is 0. The program counter clears to 0, so the first fetch reads word 0.
- R2: Fetch takes five cycles. In step 1 MAR is loaded from PC. In step 2 MDR is loaded from memory at MAR and PC is incremented. In step 3 IR is loaded from MDR. In step 4 MAR is loaded from IR bits 11:0. In step 5 the opcode IR bits 15:12 is latched into the decoder. `mem_addr` always shows MAR and `mem_wdata` always shows MDR.
- R3: Opcode 1 (store) copies A into MDR in step 6. In step 7 it raises `mem_we` for exactly one cycle to write MDR to memory at MAR.
- R4: Opcode 2 (load) reads memory at MAR into MDR in step 6 and copies MDR into A in step 7.
- R5: Opcode 3 (add) reads memory into MDR in step 6. In step 7 it computes C = A + MDR, modulo 2^16. In step 8 it copies C into A.
- R6: Opcode 4 (end) sets `halted` in step 6. From then until reset, PC, MAR, MDR and A hold their values, and `mem_we` stays 0.
- R7: Opcode 5 (jump) loads PC from IR bits 11:0 in step 6. The next fetch reads from that address.
- R8: Every other opcode, 0 and 6 to 15 included, does nothing in step 6 and takes six cycles in total.
- R9: In every cycle at most one source drives the internal bus. The word written by a store is exactly the accumulator value.
- R10: Exactly one step bit is active at all times. After the last step of an instruction the ring returns to step 1. Instruction lengths are therefore 7 cycles for store and load, 8 for add, and 6 for end, jump and the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 16 | Memory read data for `mem_addr`, valid in the same cycle |
| mem_addr | output | 12 | Word address (contents of MAR) |
| mem_wdata | output | 16 | Write data (contents of MDR) |
| mem_we | output | 1 | Write enable, one cycle per store |
| halted | output | 1 | High after an end instruction until reset |

## Verification
The assertions rely on the memory behaving as a combinational read port with a synchronous write port. The fetch and execute properties depend on `mem_rdata` settling in the same cycle that MAR changes. The bench keeps to that model by driving `mem_rdata` as a continuous lookup into an array that it writes only on clock edges, and only when `mem_we` is high. Reset is applied and released only on falling clock edges, so the ring and halt properties never see a reset edge in the middle of a cycle.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted
);
  localparam int OP_W  = DATA_W - ADDR_W;
  localparam int NSTEP = 8;
  localparam int NSRC  = 5;
  localparam int S_PC = 0, S_MDR = 1, S_IR = 2, S_A = 3, S_C = 4;
  localparam int OP_ST = 1, OP_LD = 2, OP_ADD = 3, OP_END = 4, OP_JMP = 5;

  logic [NSTEP-1:0]  t;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, ir, a, c, bus;
  logic [OP_W-1:0]   op;
  logic              halt_q, run, last;
  logic [5:1]        dec;
  logic [NSRC-1:0]   bus_sel;
  logic st_a2mdr, st_wr, rd_mdr, ld_a, add_c, add_a, stop, jmp;

  assign run = !halt_q;

  for (genvar k = 1; k < 6; k++) begin : g_dec
    assign dec[k] = run && (op == OP_W'(k));
  end

  assign st_a2mdr = t[5] & dec[OP_ST];
  assign st_wr    = t[6] & dec[OP_ST];
  assign rd_mdr   = t[5] & (dec[OP_LD] | dec[OP_ADD]);
  assign ld_a     = t[6] & dec[OP_LD];
  assign add_c    = t[6] & dec[OP_ADD];
  assign add_a    = t[7] & dec[OP_ADD];
  assign stop     = t[5] & dec[OP_END];
  assign jmp      = t[5] & dec[OP_JMP];

  assign last = (t[5] & ~(dec[OP_ST] | dec[OP_LD] | dec[OP_ADD]))
              | (t[6] & (dec[OP_ST] | dec[OP_LD]))
              | t[7];

  assign bus_sel[S_PC]  = run & t[0];
  assign bus_sel[S_MDR] = (run & t[2]) | ld_a | add_c;
  assign bus_sel[S_IR]  = (run & t[3]) | jmp;
  assign bus_sel[S_A]   = st_a2mdr;
  assign bus_sel[S_C]   = add_a;

  assign bus = ({DATA_W{bus_sel[S_PC]}}  & {{OP_W{1'b0}}, pc})
             | ({DATA_W{bus_sel[S_MDR]}} & mdr)
             | ({DATA_W{bus_sel[S_IR]}}  & {{OP_W{1'b0}}, ir[ADDR_W-1:0]})
             | ({DATA_W{bus_sel[S_A]}}   & a)
             | ({DATA_W{bus_sel[S_C]}}   & c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t      <= NSTEP'(1);
      pc     <= '0;
      mar    <= '0;
      mdr    <= '0;
      ir     <= '0;
      a      <= '0;
      c      <= '0;
      op     <= '0;
      halt_q <= 1'b0;
    end else if (run) begin
      t <= last ? NSTEP'(1) : (t << 1);
      if (t[0] | t[3]) mar <= bus[ADDR_W-1:0];
      if (t[1]) pc <= pc + 1'b1;
      else if (jmp) pc <= bus[ADDR_W-1:0];
      if (t[1] | rd_mdr) mdr <= mem_rdata;
      else if (st_a2mdr) mdr <= bus;
      if (t[2]) ir <= bus;
      if (t[4]) op <= ir[DATA_W-1:ADDR_W];
      if (ld_a | add_a) a <= bus;
      if (add_c) c <= a + bus;
      if (stop) halt_q <= 1'b1;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = st_wr;
  assign halted    = halt_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int NSTEP  = 8,
  parameter int NSRC   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSTEP-1:0]  t,
  input logic [NSRC-1:0]   bus_sel,
  input logic              halt_q,
  input logic              mem_we,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] mar,
  input logic [DATA_W-1:0] a
);
  // R9
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  // R10
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t) == 1);

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q && $stable(pc) && $stable(mar) && $stable(a));

  // R6
  halt_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !mem_we);

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t[0] && !halt_q) |=> mar == $past(pc));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t[1] && !halt_q) |=> pc == $past(pc) + 1'b1);
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .t(t), .bus_sel(bus_sel), .halt_q(halt_q),
  .mem_we(mem_we), .pc(pc), .mar(mar), .a(a)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mem  [0:4095];
  logic [15:0] mmem [0:4095];

  logic [11:0] m_pc, m_mar;
  logic [15:0] m_mdr, m_ir, m_a, m_c;
  logic [3:0]  m_op;
  logic        m_halt;
  int          m_step;
  logic        cmp_en = 1'b0;

  always #5 clk = ~clk;

  acc_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = '0; m_mar = '0; m_mdr = '0; m_ir = '0; m_a = '0; m_c = '0;
      m_op = '0; m_halt = 1'b0; m_step = 1;
    end else if (!m_halt) begin
      case (m_step)
        1: begin m_mar = m_pc; m_step = 2; end
        2: begin m_mdr = mmem[m_mar]; m_pc = m_pc + 1; m_step = 3; end
        3: begin m_ir = m_mdr; m_step = 4; end
        4: begin m_mar = m_ir[11:0]; m_step = 5; end
        5: begin m_op = m_ir[15:12]; m_step = 6; end
        6: begin
          case (m_op)
            4'd1: begin m_mdr = m_a; m_step = 7; end
            4'd2, 4'd3: begin m_mdr = mmem[m_mar]; m_step = 7; end
            4'd4: begin m_halt = 1'b1; m_step = 1; end
            4'd5: begin m_pc = m_ir[11:0]; m_step = 1; end
            default: m_step = 1;
          endcase
        end
        7: begin
          if (m_op == 4'd1) begin mmem[m_mar] = m_mdr; m_step = 1; end
          else if (m_op == 4'd2) begin m_a = m_mdr; m_step = 1; end
          else begin m_c = m_a + m_mdr; m_step = 8; end
        end
        default: begin m_a = m_c; m_step = 1; end
      endcase
    end
  end

  function automatic string tag_now();
    if (m_halt) return "R6";
    if (m_step == 1) return "R10";
    if (m_step <= 5) return "R2";
    case (m_op)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      logic exp_we;
      exp_we = (m_step == 7) && (m_op == 4'd1) && !m_halt;
      checks++;
      if (mem_addr !== m_mar || mem_wdata !== m_mdr || mem_we !== exp_we ||
          halted !== m_halt) begin
        fails++;
        $display("FAIL %s step %0d: addr=%h wdata=%h we=%b halted=%b expected addr=%h wdata=%h we=%b halted=%b",
                 tag_now(), m_step, mem_addr, mem_wdata, mem_we, halted,
                 m_mar, m_mdr, exp_we, m_halt);
      end
    end
  end

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_reset();
    check16("R1 mem_addr", {4'h0, mem_addr}, 16'h0000);
    check16("R1 mem_we", {15'h0, mem_we}, 16'h0000);
    check16("R1 halted", {15'h0, halted}, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mmem[i] = 16'h0000;
    mmem[0]  = 16'h2100;
    mmem[1]  = 16'h3101;
    mmem[2]  = 16'h1200;
    mmem[3]  = 16'h5008;
    mmem[4]  = 16'h1201;
    mmem[8]  = 16'h0ABC;
    mmem[9]  = 16'h9123;
    mmem[10] = 16'h3101;
    mmem[11] = 16'h1202;
    mmem[12] = 16'h2102;
    mmem[13] = 16'h3103;
    mmem[14] = 16'h1203;
    mmem[15] = 16'h4000;
    mmem[16] = 16'h1204;
    mmem[16'h100] = 16'h1234;
    mmem[16'h101] = 16'hF000;
    mmem[16'h102] = 16'h7FFF;
    mmem[16'h103] = 16'h0001;
    for (int i = 0; i < 4096; i++) mem[i] = mmem[i];

    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    cmp_en = 1'b1;

    begin
      int wd = 0;
      while (!halted && wd < 2000) begin
        @(negedge clk);
        wd++;
      end
      if (!halted) begin
        checks++;
        fails++;
        $display("FAIL R6 watchdog: actual halted=0 expected halted=1");
      end
    end
    repeat (12) @(negedge clk);

    check16("R9 store of A", mem[12'h200], 16'h0234);
    check16("R7 skipped store", mem[12'h201], 16'h0000);
    check16("R5 wrapped sum", mem[12'h202], 16'hF234);
    check16("R4 load then add", mem[12'h203], 16'h8000);
    check16("R6 no store after end", mem[12'h204], 16'h0000);
    check16("R8 no-op leaves data", mem[12'h100], 16'h1234);

    cmp_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule